// File: doc/BRIEF.md
# Converter Data Register and Word Assembler

This block is the digital data path that sits between four 8-bit converter channels and the two agents that drive or read them: a processor with a small register window and a programmable-logic fabric with four 8-bit input buses and a read-back bus. It holds eight byte registers. The lower four are read/write from the processor. The upper four are read-only and are filled only by conversion results in the multiplexed four-input 10-bit mode.

For every channel it chooses the DAC word from either the fabric bus or the processor. When channels are cascaded into 9-bit pairs or one 10-bit converter, it assembles the wide word and presents the low byte to every DAC of the group. It also produces a one-hot selection of the DAC whose output is used. On the processor side a wide word is committed in one step: the upper part is latched first, and the later write of the low byte transfers both together. Conversion results arrive with a valid strobe per channel. They are split over the register file according to the mode, and they are read back as an 8-bit bus with a 2-bit extension carrying the low bits of wide results.

Top module: `conv_data_path`

## Requirements
- R1: With mode 00 (four 8-bit channels) or mode 11 (multiplexed 10-bit ADC), DAC word c, at bit offset 8·c of `dac_word_o`, equals fabric byte c (bits 8·c+7:8·c of `pl_bus_i`) when `src_pl_i[c]` is 1 and register c when it is 0. It is registered, so it appears one clock after its inputs.
- R2: With mode 01 (two 9-bit pairs, channels 0+1 and 2+3), a pair whose first-channel source bit (`src_pl_i[0]` or `src_pl_i[2]`) is 1 takes the word {bit 7 of the odd channel's bus, the even channel's byte}. Both DACs of the pair receive its low 8 bits.
- R3: With mode 10 (one 10-bit DAC), when `src_pl_i[0]` is 1 the word is {bits 7:6 of bus 1, bus 0}. All four DACs receive its low 8 bits.
- R4: In modes 01 and 10 with a processor source, register 1 (or register 3 for the second pair) holds the upper part: bit 0 in mode 01, bits 1:0 in mode 10. A write to register 0 (or 2) commits {held upper bits, written byte} to the DAC path in one step. A write of the upper register alone leaves the DAC outputs unchanged.
- R5: `dac_pick_o` is 4'b1111 in modes 00 and 11. In mode 01, bit 2p+1 equals the pair's word bit 8 and bit 2p equals its inverse. In mode 10 it is one-hot at the position given by word bits 9:8.
- R6: A result strobe `res_valid_i[c]`, with data `res_data_i` bits 10·c+9:10·c, is stored as follows. Mode 00: bits 7:0 go to register c. Mode 01, even c only: bits 7:0 go to register c and bits 8:1 to register c+1. Mode 10, channel 0 only: bits 7:0 go to register 0 and bits 9:2 to register 1. Mode 11: bits 7:0 go to register 2c and bits 9:2 to register 2c+1. Any other strobe is ignored.
- R7: `rb_data_o` is register `rb_sel_i`. `rb_ext_o` is zero, except for odd selects: in mode 01 with select 1 or 3 it is {0, bit 0 of the register below}; in mode 10 with select 1, and in mode 11 with any odd select, it is bits 1:0 of the register below.
- R8: Processor writes (`cpu_addr_i` 0 to 7 = registers 0 to 7) to registers 4 to 7 are ignored. `cpu_rdata_o` always returns the addressed register's last stored value.
- R9: When a result and a processor write target the same register in the same cycle, the result is stored.
- R10: After a synchronous active-low reset all registers and DAC words are zero and `dac_pick_o` is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Channel grouping mode (00, 01, 10, 11) |
| src_pl_i | input | 4 | Per-channel DAC source: 1 fabric, 0 processor |
| pl_bus_i | input | 32 | Four fabric input bytes, channel c at 8·c |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_addr_i | input | 3 | Processor register index |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Processor read data of the addressed register |
| res_valid_i | input | 4 | Per-channel conversion result strobe |
| res_data_i | input | 40 | Four 10-bit results, channel c at 10·c |
| rb_sel_i | input | 3 | Read-back register select |
| rb_data_o | output | 8 | Read-back main byte |
| rb_ext_o | output | 2 | Read-back low-bit extension |
| dac_word_o | output | 32 | Four registered DAC bytes, channel c at 8·c |
| dac_pick_o | output | 4 | Which DAC output carries the converted value |

## Verification
Two functions meet in a single cycle here. A conversion result and a processor write can land on the same register. A processor write of a low register can also commit a wide DAC word while a result overwrites that same register. The random stimulus fires result strobes on about a fifth of the cycles per channel and processor writes on half of them, over a narrow address range, so both collisions occur often. A directed case also forces a result and a write onto register 0 at once. A bench model stores the result for the register file and still commits the written byte to the DAC path. Every DAC output, pick vector and read port is compared against that model on every cycle.

// File: rtl/conv_data_pkg.sv
// Shared definitions for the converter data path.
// Assumes four physical channels; grouping modes are fixed encodings.
package conv_data_pkg;
    typedef enum logic [1:0] {
        M_QUAD8  = 2'b00,   // four independent 8-bit channels
        M_PAIR9  = 2'b01,   // two 9-bit pairs (0+1, 2+3)
        M_WIDE10 = 2'b10,   // one 10-bit DAC from all four
        M_MUX10  = 2'b11    // multiplexed four-input 10-bit ADC
    } conv_mode_e;
endpackage

// File: rtl/conv_regfile.sv
// Byte register file shared by processor and conversion results.
// Registers 0..NCH-1 are processor read/write, NCH..2*NCH-1 read-only.
// Results are split over registers by mode and win over a processor write.
module conv_regfile
    import conv_data_pkg::*;
#(
    parameter int BW  = 8,
    parameter int NCH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  conv_mode_e                mode_i,
    input  logic                      cpu_we_i,
    input  logic [$clog2(2*NCH)-1:0]  cpu_addr_i,
    input  logic [BW-1:0]             cpu_wdata_i,
    input  logic [NCH-1:0]            res_valid_i,
    input  logic [NCH*(BW+2)-1:0]     res_data_i,
    output logic [2*NCH*BW-1:0]       regs_o
);
    localparam int RW   = BW + 2;
    localparam int NREG = 2 * NCH;
    localparam int AW   = $clog2(NREG);

    logic [BW-1:0] r_q [NREG];
    logic [BW-1:0] r_n [NREG];

    // Next register values: processor write first, results override it.
    always_comb begin
        logic [RW-1:0] res;
        for (int k = 0; k < NREG; k++) r_n[k] = r_q[k];
        if (cpu_we_i && !cpu_addr_i[AW-1]) r_n[cpu_addr_i] = cpu_wdata_i;
        for (int c = 0; c < NCH; c++) begin
            res = res_data_i[c*RW +: RW];
            if (res_valid_i[c]) begin
                unique case (mode_i)
                    M_QUAD8: r_n[c] = res[BW-1:0];
                    M_PAIR9: if (c % 2 == 0) begin
                        r_n[c]   = res[BW-1:0];
                        r_n[c+1] = res[BW:1];
                    end
                    M_WIDE10: if (c == 0) begin
                        r_n[0] = res[BW-1:0];
                        r_n[1] = res[BW+1:2];
                    end
                    default: begin
                        r_n[2*c]   = res[BW-1:0];
                        r_n[2*c+1] = res[BW+1:2];
                    end
                endcase
            end
        end
    end

    // Register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) r_q[k] <= '0;
        end else begin
            for (int k = 0; k < NREG; k++) r_q[k] <= r_n[k];
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_flat
        assign regs_o[k*BW +: BW] = r_q[k];
    end

    // R8: read-only bank untouched outside the multiplexed mode
    a_r8_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != M_MUX10) |=> $stable(regs_o[NREG*BW-1:NCH*BW]));

    // R8: plain processor write is stored
    a_r8_rw_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && cpu_addr_i == AW'(1) && mode_i == M_QUAD8 && !res_valid_i[1])
        |=> (r_q[1] == $past(cpu_wdata_i)));

    // R9: result wins over a colliding processor write
    a_r9_result_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && cpu_addr_i == '0 && mode_i == M_QUAD8 && res_valid_i[0])
        |=> (r_q[0] == $past(res_data_i[BW-1:0])));

    // R6: multiplexed mode places the upper result bits in the odd register
    a_r6_mux_split: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_MUX10 && res_valid_i[NCH-1])
        |=> (r_q[NREG-1] == $past(res_data_i[(NCH-1)*RW+2 +: BW])));
endmodule

// File: rtl/conv_dac_asm.sv
// DAC word assembler: per-channel source choice, wide-word commit from
// the processor, low-byte fan-out and pick vector for cascaded groups.
// Assumes NCH = 4 and two pairs; outputs are registered.
module conv_dac_asm
    import conv_data_pkg::*;
#(
    parameter int BW  = 8,
    parameter int NCH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  conv_mode_e                mode_i,
    input  logic [NCH-1:0]            src_pl_i,
    input  logic [NCH*BW-1:0]         pl_bus_i,
    input  logic [NCH*BW-1:0]         rw_regs_i,
    input  logic                      cpu_we_i,
    input  logic [$clog2(2*NCH)-1:0]  cpu_addr_i,
    input  logic [BW-1:0]             cpu_wdata_i,
    output logic [NCH*BW-1:0]         dac_word_o,
    output logic [NCH-1:0]            dac_pick_o
);
    localparam int AW    = $clog2(2*NCH);
    localparam int NPAIR = NCH / 2;

    logic [BW-1:0]   pl  [NCH];
    logic [BW-1:0]   rg  [NCH];
    logic [BW:0]     cw9_q [NPAIR];
    logic [BW+1:0]   cw10_q;
    logic [BW-1:0]   word_n [NCH];
    logic [BW-1:0]   word_q [NCH];
    logic [NCH-1:0]  pick_n, pick_q;

    for (genvar c = 0; c < NCH; c++) begin : g_unpack
        assign pl[c] = pl_bus_i[c*BW +: BW];
        assign rg[c] = rw_regs_i[c*BW +: BW];
        assign dac_word_o[c*BW +: BW] = word_q[c];
    end
    assign dac_pick_o = pick_q;

    // Commit wide processor words when the low register is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPAIR; p++) cw9_q[p] <= '0;
            cw10_q <= '0;
        end else if (cpu_we_i) begin
            if (mode_i == M_PAIR9) begin
                for (int p = 0; p < NPAIR; p++)
                    if (cpu_addr_i == AW'(2*p)) cw9_q[p] <= {rg[2*p+1][0], cpu_wdata_i};
            end
            if (mode_i == M_WIDE10 && cpu_addr_i == '0)
                cw10_q <= {rg[1][1:0], cpu_wdata_i};
        end
    end

    // Select and fan out the next DAC words and pick vector.
    always_comb begin
        logic [BW:0]   w9;
        logic [BW+1:0] w10;
        pick_n = '1;
        w9  = '0;
        w10 = '0;
        for (int c = 0; c < NCH; c++) word_n[c] = src_pl_i[c] ? pl[c] : rg[c];
        unique case (mode_i)
            M_PAIR9: begin
                for (int p = 0; p < NPAIR; p++) begin
                    w9 = src_pl_i[2*p] ? {pl[2*p+1][BW-1], pl[2*p]} : cw9_q[p];
                    word_n[2*p]   = w9[BW-1:0];
                    word_n[2*p+1] = w9[BW-1:0];
                    pick_n[2*p]   = ~w9[BW];
                    pick_n[2*p+1] = w9[BW];
                end
            end
            M_WIDE10: begin
                w10 = src_pl_i[0] ? {pl[1][BW-1:BW-2], pl[0]} : cw10_q;
                for (int c = 0; c < NCH; c++) word_n[c] = w10[BW-1:0];
                pick_n = NCH'(1) << w10[BW+1:BW];
            end
            default: ;
        endcase
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) word_q[c] <= '0;
            pick_q <= '1;
        end else begin
            for (int c = 0; c < NCH; c++) word_q[c] <= word_n[c];
            pick_q <= pick_n;
        end
    end

    // R2: both DACs of a pair carry the same low byte
    a_r2_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_PAIR9) |=> (word_q[0] == word_q[1] && word_q[2] == word_q[3]));

    // R5: exactly one DAC picked in 10-bit mode
    a_r5_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_WIDE10) |=> ($countones(pick_q) == 1));

    // R5: one DAC of each pair picked in 9-bit mode
    a_r5_pair_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_PAIR9) |=> (pick_q[0] != pick_q[1] && pick_q[2] != pick_q[3]));

    // R4: low-byte write reaches the DAC two clocks later
    a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && cpu_addr_i == '0 && mode_i == M_WIDE10 && !src_pl_i[0])
        ##1 (mode_i == M_WIDE10 && !src_pl_i[0])
        |=> (word_q[0] == $past(cpu_wdata_i, 2)));

    // R4: upper write alone leaves the DAC output unchanged
    a_r4_upper_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && cpu_addr_i == AW'(1) && mode_i == M_WIDE10 && !src_pl_i[0])
        ##1 (mode_i == M_WIDE10 && !src_pl_i[0] && !(cpu_we_i && cpu_addr_i == '0))
        |=> ($stable(word_q[0]) && $stable(pick_q)));
endmodule

// File: rtl/conv_readback.sv
// Read ports: processor read of any register, and the fabric read-back
// byte with a 2-bit extension carrying the low bits of wide results.
// Purely combinational; assumes the register layout of conv_regfile.
module conv_readback
    import conv_data_pkg::*;
#(
    parameter int BW  = 8,
    parameter int NCH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  conv_mode_e                mode_i,
    input  logic [2*NCH*BW-1:0]       regs_i,
    input  logic [$clog2(2*NCH)-1:0]  cpu_addr_i,
    input  logic [$clog2(2*NCH)-1:0]  rb_sel_i,
    output logic [BW-1:0]             cpu_rdata_o,
    output logic [BW-1:0]             rb_data_o,
    output logic [1:0]                rb_ext_o
);
    localparam int NREG = 2 * NCH;
    localparam int AW   = $clog2(NREG);

    logic [BW-1:0] r [NREG];
    logic [BW-1:0] below;

    for (genvar k = 0; k < NREG; k++) begin : g_unpack
        assign r[k] = regs_i[k*BW +: BW];
    end

    assign cpu_rdata_o = r[cpu_addr_i];
    assign rb_data_o   = r[rb_sel_i];
    assign below       = r[{rb_sel_i[AW-1:1], 1'b0}];

    // Extension bits: low bits of the wide result whose upper part is selected.
    always_comb begin
        rb_ext_o = 2'b00;
        if (rb_sel_i[0]) begin
            unique case (mode_i)
                M_PAIR9:  if (!rb_sel_i[AW-1]) rb_ext_o = {1'b0, below[0]};
                M_WIDE10: if (rb_sel_i == AW'(1)) rb_ext_o = below[1:0];
                M_MUX10:  rb_ext_o = below[1:0];
                default:  rb_ext_o = 2'b00;
            endcase
        end
    end

    // R7: no extension bits for plain 8-bit results
    a_r7_quad_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_QUAD8) |-> (rb_ext_o == 2'b00));
endmodule

// File: rtl/conv_data_path.sv
// Top of the converter data path: register file, DAC word assembler and
// read-back ports. Assumes four channels of BW-bit converters.
module conv_data_path
    import conv_data_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic [3:0]      src_pl_i,
    input  logic [4*BW-1:0] pl_bus_i,
    input  logic            cpu_we_i,
    input  logic [2:0]      cpu_addr_i,
    input  logic [BW-1:0]   cpu_wdata_i,
    output logic [BW-1:0]   cpu_rdata_o,
    input  logic [3:0]      res_valid_i,
    input  logic [4*(BW+2)-1:0] res_data_i,
    input  logic [2:0]      rb_sel_i,
    output logic [BW-1:0]   rb_data_o,
    output logic [1:0]      rb_ext_o,
    output logic [4*BW-1:0] dac_word_o,
    output logic [3:0]      dac_pick_o
);
    localparam int NCH = 4;

    conv_mode_e         mode;
    logic [2*NCH*BW-1:0] regs;

    assign mode = conv_mode_e'(mode_i);

    conv_regfile #(.BW(BW), .NCH(NCH)) i_regfile (
        .clk, .rst_n, .mode_i(mode),
        .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
        .res_valid_i, .res_data_i,
        .regs_o(regs)
    );

    conv_dac_asm #(.BW(BW), .NCH(NCH)) i_dac_asm (
        .clk, .rst_n, .mode_i(mode),
        .src_pl_i, .pl_bus_i,
        .rw_regs_i(regs[NCH*BW-1:0]),
        .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
        .dac_word_o, .dac_pick_o
    );

    conv_readback #(.BW(BW), .NCH(NCH)) i_readback (
        .clk, .rst_n, .mode_i(mode),
        .regs_i(regs), .cpu_addr_i, .rb_sel_i,
        .cpu_rdata_o, .rb_data_o, .rb_ext_o
    );
endmodule

// File: tb/test_conv_data_path.sv
module test_conv_data_path;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = '0;  logic [3:0] src = '0;  logic [31:0] pl = '0;
    logic we = 1'b0;  logic [2:0] addr = '0;  logic [7:0] wdata = '0;
    logic [3:0] rv = '0;  logic [39:0] rd = '0;  logic [2:0] rbs = '0;
    logic [7:0] rdata, rb_data;  logic [1:0] rb_ext;
    logic [31:0] dac;  logic [3:0] pick;

    logic [1:0] n_mode = '0;  logic [3:0] n_src = '0;  logic [31:0] n_pl = '0;
    logic n_we = 1'b0;  logic [2:0] n_addr = '0;  logic [7:0] n_wdata = '0;
    logic [3:0] n_rv = '0;  logic [39:0] n_rd = '0;  logic [2:0] n_rbs = '0;

    logic [7:0] m_dat [8];
    logic [8:0] m_cw9 [2];
    logic [9:0] m_cw10;
    logic [7:0] e_dac [4];
    logic [3:0] e_pick;
    logic [1:0] l_mode;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    conv_data_path i_conv_data_path (
        .clk, .rst_n, .mode_i(mode), .src_pl_i(src), .pl_bus_i(pl),
        .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
        .res_valid_i(rv), .res_data_i(rd), .rb_sel_i(rbs),
        .rb_data_o(rb_data), .rb_ext_o(rb_ext),
        .dac_word_o(dac), .dac_pick_o(pick)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string dac_tag(logic [1:0] m);
        return (m == 2'b01) ? "R2" : (m == 2'b10) ? "R3" : "R1";
    endfunction

    function automatic logic [1:0] exp_ext();
        logic [7:0] b;
        b = m_dat[{rbs[2:1], 1'b0}];
        if (!rbs[0]) return 2'b00;
        case (mode)
            2'b01:   return rbs[2] ? 2'b00 : {1'b0, b[0]};
            2'b10:   return (rbs == 3'd1) ? b[1:0] : 2'b00;
            2'b11:   return b[1:0];
            default: return 2'b00;
        endcase
    endfunction

    // Model of one clock edge from pre-edge state and the applied inputs.
    task automatic model_step();
        logic [7:0] nd [4];  logic [3:0] np;  logic [8:0] w9;  logic [9:0] w10;
        logic [7:0] nr [8];  logic [9:0] res;
        np = 4'hF;
        for (int c = 0; c < 4; c++) nd[c] = src[c] ? pl[c*8 +: 8] : m_dat[c];
        if (mode == 2'b01) begin
            for (int p = 0; p < 2; p++) begin
                w9 = src[2*p] ? {pl[(2*p+1)*8+7], pl[2*p*8 +: 8]} : m_cw9[p];
                nd[2*p] = w9[7:0];  nd[2*p+1] = w9[7:0];
                np[2*p] = ~w9[8];   np[2*p+1] = w9[8];
            end
        end else if (mode == 2'b10) begin
            w10 = src[0] ? {pl[15:14], pl[7:0]} : m_cw10;
            for (int c = 0; c < 4; c++) nd[c] = w10[7:0];
            np = 4'b0001 << w10[9:8];
        end
        if (we && mode == 2'b01 && addr == 3'd0) m_cw9[0] = {m_dat[1][0], wdata};
        if (we && mode == 2'b01 && addr == 3'd2) m_cw9[1] = {m_dat[3][0], wdata};
        if (we && mode == 2'b10 && addr == 3'd0) m_cw10 = {m_dat[1][1:0], wdata};
        for (int k = 0; k < 8; k++) nr[k] = m_dat[k];
        if (we && !addr[2]) nr[addr] = wdata;
        for (int c = 0; c < 4; c++) begin
            res = rd[c*10 +: 10];
            if (rv[c]) begin
                case (mode)
                    2'b00: nr[c] = res[7:0];
                    2'b01: if (c % 2 == 0) begin nr[c] = res[7:0]; nr[c+1] = res[8:1]; end
                    2'b10: if (c == 0) begin nr[0] = res[7:0]; nr[1] = res[9:2]; end
                    default: begin nr[2*c] = res[7:0]; nr[2*c+1] = res[9:2]; end
                endcase
            end
        end
        for (int k = 0; k < 8; k++) m_dat[k] = nr[k];
        for (int c = 0; c < 4; c++) e_dac[c] = nd[c];
        e_pick = np;
    endtask

    task automatic cycle();
        @(negedge clk);
        for (int c = 0; c < 4; c++)
            chk(dac[c*8 +: 8] == e_dac[c], dac_tag(l_mode), dac[c*8 +: 8], e_dac[c]);
        chk(pick == e_pick, "R5", pick, e_pick);
        mode = n_mode; src = n_src; pl = n_pl; we = n_we; addr = n_addr;
        wdata = n_wdata; rv = n_rv; rd = n_rd; rbs = n_rbs;
        #1;
        chk(rdata == m_dat[addr], "R8", rdata, m_dat[addr]);
        chk(rb_data == m_dat[rbs], "R7", rb_data, m_dat[rbs]);
        chk(rb_ext == exp_ext(), "R7", rb_ext, exp_ext());
        model_step();
        l_mode = mode;
    endtask

    task automatic idle();
        n_we = 1'b0; n_rv = '0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        n_we = 1'b1; n_addr = a; n_wdata = d; n_rv = '0;
        cycle();
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        for (int k = 0; k < 8; k++) m_dat[k] = '0;
        m_cw9[0] = '0; m_cw9[1] = '0; m_cw10 = '0;
        for (int c = 0; c < 4; c++) e_dac[c] = '0;
        e_pick = 4'hF; l_mode = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(dac == 32'h0, "R10", dac, 32'h0);
        chk(pick == 4'hF, "R10", pick, 4'hF);
        chk(rdata == 8'h0, "R10", rdata, 8'h0);

        // R4: upper part latched first, low write commits atomically
        n_mode = 2'b10; n_src = 4'b0000; idle();
        cycle(); cycle();
        wr(3'd1, 8'h02);
        cycle(); cycle();
        chk(dac == 32'h0, "R4", dac, 32'h0);
        chk(pick == 4'b0001, "R4", pick, 4'b0001);
        wr(3'd0, 8'h5A);
        cycle(); cycle();
        chk(dac == 32'h5A5A5A5A, "R4", dac, 32'h5A5A5A5A);
        chk(pick == 4'b0100, "R4", pick, 4'b0100);

        // R3: 10-bit word from fabric buses
        n_src = 4'b0001; n_pl = 32'h0000_C012;
        cycle(); cycle();
        chk(dac == 32'h12121212, "R3", dac, 32'h12121212);
        chk(pick == 4'b1000, "R3", pick, 4'b1000);

        // R2: 9-bit pairs from fabric buses
        n_mode = 2'b01; n_src = 4'b0101; n_pl = 32'h0056_8034;
        cycle(); cycle();
        chk(dac == 32'h56563434, "R2", dac, 32'h56563434);
        chk(pick == 4'b0110, "R5", pick, 4'b0110);

        // R1: per-channel source mix in 8-bit mode
        n_mode = 2'b00; n_src = 4'b1010; n_pl = 32'hDDCC_BBAA;
        cycle(); cycle();
        chk(dac == 32'hDD00BB5A, "R1", dac, 32'hDD00BB5A);

        // R8: read-only register ignores a processor write
        wr(3'd5, 8'hFF);
        wr(3'd3, 8'h77);
        n_addr = 3'd5; cycle();
        chk(rdata == 8'h00, "R8", rdata, 8'h00);
        n_addr = 3'd3; cycle();
        chk(rdata == 8'h77, "R8", rdata, 8'h77);

        // R9: result and processor write on the same register
        n_we = 1'b1; n_addr = 3'd0; n_wdata = 8'h11; n_rv = 4'b0001;
        n_rd = 40'h0_0000_03C5;
        cycle(); idle();
        n_addr = 3'd0; cycle();
        chk(rdata == 8'hC5, "R9", rdata, 8'hC5);

        // R6/R7: multiplexed 10-bit result split and read back
        n_mode = 2'b11; n_rv = 4'b1000; n_rd = {10'h2B7, 30'h0};
        cycle(); idle();
        n_rbs = 3'd7; n_addr = 3'd6; cycle();
        chk(rb_data == 8'hAD, "R7", rb_data, 8'hAD);
        chk(rb_ext == 2'b11, "R7", rb_ext, 2'b11);
        chk(rdata == 8'hB7, "R6", rdata, 8'hB7);

        // Random phase: every cycle compared against the model (R1..R9)
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 50 == 0) n_mode = 2'($urandom);
            if ($urandom % 20 == 0) n_src = 4'($urandom);
            n_pl = $urandom;
            n_we = 1'($urandom);
            n_addr = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 4);
            n_wdata = 8'($urandom);
            for (int c = 0; c < 4; c++) n_rv[c] = ($urandom % 5 == 0);
            n_rd = {8'($urandom), $urandom};
            n_rbs = 3'($urandom);
            cycle();
        end
        idle(); cycle(); cycle();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule